// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory 32-bit Processor Core

This block is a 32-bit processor core that spends several clock cycles on every instruction. A finite-state machine steps each instruction through fetch, decode and a short opcode-specific tail. One memory port carries both instruction fetches and data loads and stores. One adder/subtractor serves the program-counter increment, the branch-target sum, the load/store address sum and the register arithmetic. Values that must survive into a later cycle are held in internal registers: the instruction word, the two register operands, the ALU result and the loaded data word.

The instruction set holds register add and subtract, word load, word store, branch-if-equal and an absolute jump. The memory attached to the port reads combinationally: the word at `mem_addr` must appear on `mem_rdata` in the same cycle. A store is one cycle with `mem_we` high, and the memory takes `mem_wdata` at the next rising clock edge.

The states are FETCH, DECODE, ADDR (effective-address sum), LOAD (data read), LOADWB (load write-back), STORE, EXEC (register arithmetic), ALUWB (arithmetic write-back), BRANCH and JUMP. The transitions are:
- FETCH always goes to DECODE.
- DECODE goes to ADDR for loads and stores, to EXEC for register instructions, to BRANCH for branches and to JUMP for jumps. Any other opcode returns to FETCH.
- ADDR goes to LOAD for a load and to STORE for a store. LOAD goes to LOADWB.
- EXEC goes to ALUWB.
- LOADWB, STORE, ALUWB, BRANCH and JUMP all return to FETCH.

Top module: `mc_core`

## Requirements
- R1: While reset (`rst_n` low) is held, `mem_addr` is 0 and `mem_we` is 0. All 32 general registers are cleared, and the first fetch after reset reads address 0.
- R2: The first cycle of every instruction drives the program counter on `mem_addr` with `mem_we` low. A non-control instruction is followed by a fetch at that address plus 4.
- R3: The cycle counts are fixed: 4 for register arithmetic, 5 for a load, 4 for a store, and 3 each for a branch and a jump. The next fetch therefore appears exactly that many cycles after the current one.
- R4: A register instruction has opcode bits [31:26] = 0x00, sources in bits [25:21] and [20:16], and its destination in bits [15:11]. Function field [5:0] = 0x22 subtracts the second source from the first; any other function value adds them.
- R5: A load has opcode 0x23. Its address is the register named by bits [25:21] plus the sign-extended bits [15:0]. The 4th cycle places that address on `mem_addr` with `mem_we` low, and the word read is written to the register named by bits [20:16].
- R6: A store has opcode 0x2B and computes its address the same way as a load. In its 4th cycle `mem_addr` carries that address, `mem_we` is 1, and `mem_wdata` carries the register named by bits [20:16].
- R7: A branch has opcode 0x04. When the registers named by bits [25:21] and [20:16] are equal, the next fetch address is PC+4 plus the sign-extended bits [15:0] times 4. Otherwise it is PC+4.
- R8: A jump has opcode 0x02. Its next fetch address is bits [31:28] of PC+4, then bits [25:0] of the instruction, then two zero bits.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: `mem_we` is high only in the 4th cycle of a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for instruction fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, taken at the next rising edge |
| mem_rdata | input | 32 | Combinational read data for `mem_addr` |

## Verification
A wrong state transition or a wrong program-counter update shows within a few cycles as a fetch address that differs from the expected one, or as a fetch arriving one cycle early or late. A corrupted operand or result register stays hidden until a store sends that register to the port. For this reason the stimulus stores results often, and at each such store it reports which kind of instruction last wrote the offending register. Store strobes outside the store cycle are flagged in the very cycle they appear.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] FN_SUB    = 6'h22;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_LOAD,
        ST_LOADWB,
        ST_STORE,
        ST_EXEC,
        ST_ALUWB,
        ST_BRANCH,
        ST_JUMP
    } state_e;

    typedef enum logic {
        ALU_ADD,
        ALU_SUB
    } aluop_e;

    typedef enum logic [1:0] {
        SRCB_REG,
        SRCB_FOUR,
        SRCB_IMM,
        SRCB_BROFF
    } srcb_e;

    typedef enum logic [1:0] {
        PCN_ALU,
        PCN_HELD,
        PCN_JUMP
    } pcsrc_e;

    typedef struct packed {
        logic   pc_we;
        logic   pc_we_eq;
        pcsrc_e pc_src;
        logic   ir_we;
        logic   ab_we;
        logic   res_we;
        logic   mdr_we;
        logic   rf_we;
        logic   rf_dst_rd;
        logic   rf_from_mdr;
        logic   srca_pc;
        srcb_e  srcb;
        aluop_e aluop;
        logic   addr_data;
        logic   mem_we;
    } ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] bank [N];

    // Entry 0 is never written, so it holds its reset value of zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                bank[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            bank[wa] <= wd;
        end
    end

    assign rd1 = bank[ra1];
    assign rd2 = bank[ra2];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluop_e       op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_ADD: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output state_e     state,
    output ctrl_t      ctl
);

    state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD, OPC_STORE: state_nx = ST_ADDR;
                    OPC_REG:             state_nx = ST_EXEC;
                    OPC_BEQ:             state_nx = ST_BRANCH;
                    OPC_JUMP:            state_nx = ST_JUMP;
                    default:             state_nx = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_nx = (opcode == OPC_LOAD) ? ST_LOAD : ST_STORE;
            ST_LOAD:   state_nx = ST_LOADWB;
            ST_EXEC:   state_nx = ST_ALUWB;
            ST_LOADWB,
            ST_STORE,
            ST_ALUWB,
            ST_BRANCH,
            ST_JUMP:   state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH: begin
                ctl.ir_we   = 1'b1;
                ctl.srca_pc = 1'b1;
                ctl.srcb    = SRCB_FOUR;
                ctl.aluop   = ALU_ADD;
                ctl.pc_we   = 1'b1;
                ctl.pc_src  = PCN_ALU;
            end
            ST_DECODE: begin
                ctl.ab_we   = 1'b1;
                ctl.srca_pc = 1'b1;
                ctl.srcb    = SRCB_BROFF;
                ctl.aluop   = ALU_ADD;
                ctl.res_we  = 1'b1;
            end
            ST_ADDR: begin
                ctl.srcb    = SRCB_IMM;
                ctl.aluop   = ALU_ADD;
                ctl.res_we  = 1'b1;
            end
            ST_LOAD: begin
                ctl.addr_data = 1'b1;
                ctl.mdr_we    = 1'b1;
            end
            ST_LOADWB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_from_mdr = 1'b1;
            end
            ST_STORE: begin
                ctl.addr_data = 1'b1;
                ctl.mem_we    = 1'b1;
            end
            ST_EXEC: begin
                ctl.srcb   = SRCB_REG;
                ctl.aluop  = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
                ctl.res_we = 1'b1;
            end
            ST_ALUWB: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl.srcb     = SRCB_REG;
                ctl.aluop    = ALU_SUB;
                ctl.pc_we_eq = 1'b1;
                ctl.pc_src   = PCN_HELD;
            end
            ST_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCN_JUMP;
            end
        endcase
    end

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              NREG     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int RAW = $clog2(NREG);

    state_e          state;
    ctrl_t           ctl;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, pc_nx;
    logic [XLEN-1:0] imm_sx, imm_br;
    logic            alu_zero, pc_load;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_q[31:26]),
        .funct  (ir_q[5:0]),
        .state  (state),
        .ctl    (ctl)
    );

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (RAW'(ir_q[25:21])),
        .ra2   (RAW'(ir_q[20:16])),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (ctl.rf_we),
        .wa    (ctl.rf_dst_rd ? RAW'(ir_q[15:11]) : RAW'(ir_q[20:16])),
        .wd    (ctl.rf_from_mdr ? mdr_q : res_q)
    );

    assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign imm_br = {{(XLEN-18){ir_q[15]}}, ir_q[15:0], 2'b00};

    assign alu_a = ctl.srca_pc ? pc_q : a_q;

    always_comb begin
        unique case (ctl.srcb)
            SRCB_REG:   alu_b = b_q;
            SRCB_FOUR:  alu_b = XLEN'(4);
            SRCB_IMM:   alu_b = imm_sx;
            SRCB_BROFF: alu_b = imm_br;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.aluop),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        pc_nx = alu_y;
        unique case (ctl.pc_src)
            PCN_ALU:  pc_nx = alu_y;
            PCN_HELD: pc_nx = res_q;
            PCN_JUMP: pc_nx = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
            default:  pc_nx = alu_y;
        endcase
    end

    assign pc_load = ctl.pc_we | (ctl.pc_we_eq & alu_zero);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (pc_load)    pc_q  <= pc_nx;
            if (ctl.ir_we)  ir_q  <= mem_rdata;
            if (ctl.ab_we) begin
                a_q <= rf_rd1;
                b_q <= rf_rd2;
            end
            if (ctl.res_we) res_q <= alu_y;
            if (ctl.mdr_we) mdr_q <= mem_rdata;
        end
    end

    assign mem_addr  = ctl.addr_data ? res_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_e      state,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic [31:0] a_q,
    input logic [31:0] b_q,
    input logic [31:0] res_q,
    input logic        mem_we
);

    // R10: a store strobe only follows the address cycle
    a_r10_we_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(state) == ST_ADDR));

    // R2: the instruction word changes only on the edge that leaves fetch
    a_r2_ir_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DECODE) |-> $stable(ir));

    // R2: the program counter moves only after fetch, branch or jump
    a_r2_pc_writers: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> ($past(state) == ST_FETCH || $past(state) == ST_BRANCH
                          || $past(state) == ST_JUMP));

    // R7: equal operands in the branch cycle load the held target
    a_r7_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && a_q == b_q) |=> (pc == $past(res_q)));

    // R9: register 0 read as an operand is zero
    a_r9_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir[25:21] == 5'd0) |-> (a_q == 32'd0));

    // R3: fetch is always followed by decode, write-back by fetch
    a_r3_fetch_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    a_r3_aluwb_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALUWB) |=> (state == ST_FETCH));

endmodule

bind mc_core mc_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .pc     (pc_q),
    .ir     (ir_q),
    .a_q    (a_q),
    .b_q    (b_q),
    .res_q  (res_q),
    .mem_we (mem_we)
);

// File: tb/mc_core_test.sv
module mc_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic [31:0] mem     [MEM_WORDS];
    logic [31:0] ref_mem [MEM_WORDS];
    logic [31:0] ref_rf  [32];
    string       ref_tag [32];
    logic [31:0] ref_pc;
    string       prev_kind;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        return (fn == 6'h22) ? a - b : a + b;
    endfunction

    function automatic logic [31:0] ref_sext(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic put(input int idx, input logic [31:0] v);
        mem[idx]     = v;
        ref_mem[idx] = v;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) put(i, 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) begin
            ref_rf[i]  = 32'd0;
            ref_tag[i] = "R1";
        end
        ref_tag[0] = "R9";
        ref_pc     = 32'd0;
        prev_kind  = "R1";
        repeat (2) @(negedge clk);
        check(mem_addr == 32'd0, "R1 address in reset", mem_addr, 32'd0);
        check(mem_we == 1'b0, "R1 strobe in reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
    endtask

    // Runs one instruction on the reference and steps the core through it.
    task automatic run_instr();
        logic [31:0] ins, pc4, ea, wd, npc, sx, res;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        int          k;
        bit          is_lw, is_sw;
        string       kind, wtag;
        ins = ref_mem[ref_pc[9:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        sx = ref_sext(ins[15:0]);
        pc4 = ref_pc + 32'd4;
        ea = ref_rf[rs] + sx;
        wd = ref_rf[rt];
        wtag = ref_tag[rt];
        npc = pc4;
        is_lw = 1'b0; is_sw = 1'b0;
        kind = "R2";
        case (op)
            6'h00: k = 4;
            6'h23: begin k = 5; is_lw = 1'b1; end
            6'h2B: begin k = 4; is_sw = 1'b1; end
            6'h04: begin
                k = 3; kind = "R7";
                if (ref_rf[rs] == ref_rf[rt]) npc = pc4 + {sx[29:0], 2'b00};
            end
            6'h02: begin
                k = 3; kind = "R8";
                npc = {pc4[31:28], ins[25:0], 2'b00};
            end
            default: k = 2;
        endcase
        for (int c = 1; c <= k; c++) begin
            logic [31:0] cap_a, cap_d;
            bit          cap_w;
            if (c == 1) begin
                check(mem_addr == ref_pc, {"R3 fetch address after ", prev_kind}, mem_addr, ref_pc);
                check(mem_we == 1'b0, "R2 no strobe in fetch", 32'(mem_we), 32'd0);
            end else if (c == 4 && is_lw) begin
                check(mem_addr == ea, "R5 load address", mem_addr, ea);
                check(mem_we == 1'b0, "R10 no strobe on load", 32'(mem_we), 32'd0);
            end else if (c == 4 && is_sw) begin
                check(mem_addr == ea, "R6 store address", mem_addr, ea);
                check(mem_we == 1'b1, "R6 store strobe", 32'(mem_we), 32'd1);
                check(mem_wdata == wd, {"R6 store data, value from ", wtag}, mem_wdata, wd);
            end else begin
                check(mem_we == 1'b0, "R10 strobe outside store", 32'(mem_we), 32'd0);
            end
            cap_w = mem_we; cap_a = mem_addr; cap_d = mem_wdata;
            @(posedge clk);
            if (cap_w) mem[cap_a[9:2]] = cap_d;
            @(negedge clk);
        end
        if (op == 6'h00) begin
            res = ref_alu(fn, ref_rf[rs], ref_rf[rt]);
            if (rd != 5'd0) begin
                ref_rf[rd]  = res;
                ref_tag[rd] = "R4";
            end
        end else if (is_lw) begin
            if (rt != 5'd0) begin
                ref_rf[rt]  = ref_mem[ea[9:2]];
                ref_tag[rt] = "R5";
            end
        end else if (is_sw) begin
            ref_mem[ea[9:2]] = wd;
        end
        prev_kind = kind;
        ref_pc = npc;
    endtask

    task automatic compare_memory();
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEM_WORDS; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, "R6 final memory image", 32'(bad), 32'd0);
    endtask

    task automatic load_directed();
        clear_mem();
        put(128, 32'h0000_0007);
        put(129, 32'hFFFF_FFF0);
        put(130, 32'h1234_5678);
        put(0,  enc_i(6'h23, 5'd0, 5'd1, 16'h0200));
        put(1,  enc_i(6'h23, 5'd0, 5'd2, 16'h0204));
        put(2,  enc_r(5'd1, 5'd2, 5'd3, 6'h20));          // R4 add -> -9
        put(3,  enc_r(5'd1, 5'd2, 5'd4, 6'h22));          // R4 sub -> 23
        put(4,  enc_i(6'h2B, 5'd0, 5'd3, 16'h0210));
        put(5,  enc_i(6'h2B, 5'd0, 5'd4, 16'h0214));
        put(6,  enc_r(5'd1, 5'd1, 5'd0, 6'h20));          // R9 write to r0
        put(7,  enc_i(6'h2B, 5'd0, 5'd0, 16'h0218));      // stores 0
        put(8,  enc_i(6'h04, 5'd1, 5'd2, 16'd5));         // R7 not taken
        put(9,  enc_i(6'h04, 5'd1, 5'd1, 16'd2));         // R7 taken -> 12
        put(10, enc_i(6'h2B, 5'd0, 5'd1, 16'h021C));
        put(11, enc_j(26'd0));
        put(12, enc_r(5'd5, 5'd1, 5'd5, 6'h20));
        put(13, enc_i(6'h04, 5'd5, 5'd1, 16'hFFFE));      // R7 backward once
        put(14, enc_i(6'h2B, 5'd0, 5'd5, 16'h0220));
        put(15, enc_j(26'd20));                           // R8
        put(20, enc_i(6'h23, 5'd0, 5'd7, 16'h0208));
        put(21, enc_i(6'h2B, 5'd0, 5'd7, 16'h0224));
        put(22, enc_j(26'd22));
    endtask

    task automatic load_random();
        clear_mem();
        for (int i = 0; i < 128; i++) begin
            int unsigned sel = $urandom_range(9, 0);
            logic [4:0]  rs  = 5'($urandom_range(7, 0));
            logic [4:0]  rt  = 5'($urandom_range(7, 0));
            logic [4:0]  rd  = 5'($urandom_range(7, 0));
            int          tgt = int'($urandom_range(127, 0));
            logic [15:0] dof = 16'(32'h200 + 4 * $urandom_range(127, 0));
            logic [5:0]  fn;
            case ($urandom_range(2, 0))
                0:       fn = 6'h20;
                1:       fn = 6'h22;
                default: fn = 6'h21;
            endcase
            if (sel <= 2)      put(i, enc_r(rs, rt, rd, fn));
            else if (sel <= 4) put(i, enc_i(6'h23, 5'd0, rt, dof));
            else if (sel <= 6) put(i, enc_i(6'h2B, 5'd0, rt, dof));
            else if (sel <= 8) begin
                if ($urandom_range(2, 0) == 0) rt = rs;
                put(i, enc_i(6'h04, rs, rt, 16'(tgt - (i + 1))));
            end else           put(i, enc_j(26'(tgt)));
        end
        for (int i = 128; i < MEM_WORDS; i++) begin
            put(i, ($urandom_range(1, 0) == 0) ? 32'($urandom_range(3, 0)) : $urandom);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        load_directed();
        do_reset();
        for (int n = 0; n < 30; n++) run_instr();
        compare_memory();
        check(mem[132] == 32'hFFFF_FFF7, "R4 add result stored", mem[132], 32'hFFFF_FFF7);
        check(mem[133] == 32'd23, "R4 sub result stored", mem[133], 32'd23);
        check(mem[134] == 32'd0, "R9 register zero stored", mem[134], 32'd0);
        check(mem[135] == 32'd0, "R7 skipped store", mem[135], 32'd0);
        check(mem[136] == 32'd14, "R7 loop result", mem[136], 32'd14);
        check(mem[137] == 32'h1234_5678, "R8 jump target path", mem[137], 32'h1234_5678);
        for (int p = 0; p < 3; p++) begin
            load_random();
            do_reset();
            for (int n = 0; n < 500; n++) run_instr();
            compare_memory();
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule